// File: doc/BRIEF.md
# Sampling ADC conversion controller

This block is the host side of a parallel-output successive-approximation converter. It drives the converter's chip-select and read/convert control lines and watches the converter's BUSY line, which is low while a conversion runs. It collects each result from the parallel data bus and hands it on with a one-cycle strobe. Conversions are started at a programmable rate, given as a period in system clock cycles.

Two sequencing modes share the same pins. In the held-select mode, chip select stays low and a pulse on read/convert alone starts each conversion. The result is latched once BUSY returns high. In the pulsed-select mode, read/convert is lowered first and a chip-select pulse then starts the conversion. The result of the previous conversion is read inside that same pulse. The converter's timing limits are given in nanoseconds and turned into cycle counts at elaboration time. Minimums are rounded up and maximums rounded down. A BUSY watchdog flags a converter that never finishes.

Top module: `adc_conv_ctrl`

## Requirements
- R1: After reset, `adc_rc` and `adc_cs_n` are high and `smp_valid` and `tmo_err` are low.
- R2: With `mode_sel` = 0, `adc_cs_n` stays low. Each start drives `adc_rc` low for exactly LOW_CYC cycles (8 at the defaults: 40 ns rounded up at 5 ns per cycle). This is well inside the maximum low time RC_MAX_CYC (600 cycles, 3 µs rounded down).
- R3: With `mode_sel` = 1, `adc_rc` falls exactly SETUP_CYC cycles (2 at the defaults) before `adc_cs_n` falls. `adc_cs_n` then stays low for exactly LOW_CYC cycles, and both lines return high on the same edge.
- R4: No start, meaning both lines low together, is issued while the converter is busy. A start needs BUSY to have been seen high through the two-flop synchronizer.
- R5: While `run_en` is high, successive starts are exactly `period_cyc` cycles apart when a conversion fits in the period. Otherwise the next start follows as soon as BUSY is seen high. With a 60-cycle conversion and a two-flop synchronizer this gives 64 cycles between starts in the held-select mode.
- R6: In the held-select mode, the bus is latched after BUSY is seen high. There is exactly one `smp_valid` pulse per conversion, one cycle wide, and `smp_data` equals the converter's new result.
- R7: In the pulsed-select mode, the bus is latched at the last cycle of each chip-select pulse and carries the previous conversion's result. The first start after entering the mode, or after a timeout, yields no strobe, so N starts give N-1 strobes.
- R8: If BUSY stays low for TMO_CYC cycles after the start pulse (2000 at the defaults, 10 µs), `tmo_err` goes high, no strobe is given and the controller returns to idle. `tmo_err` stays high until the next start.
- R9: While `run_en` is low, no start is issued. A change of `mode_sel` is taken only while idle and takes effect after one idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Allows paced conversions |
| mode_sel | input | 1 | 0 = held-select mode, 1 = pulsed-select mode |
| period_cyc | input | PW | Start-to-start period in clock cycles |
| adc_busy_n | input | 1 | Converter BUSY, low while converting (asynchronous) |
| adc_data | input | DW | Converter parallel data bus |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_rc | output | 1 | Converter read/convert: low = convert, high = read |
| smp_data | output | DW | Last captured result |
| smp_valid | output | 1 | One-cycle strobe marking new `smp_data` |
| tmo_err | output | 1 | BUSY watchdog expired |

## Verification
The assertions assume that the converter lowers BUSY only in response to a start and raises it again within the watchdog limit, unless the test deliberately holds it low. They also assume the data bus is stable whenever the addressed mode reads it. The bench's converter model follows these rules. It pulls BUSY low on the cycle after both control lines go low and releases it a fixed 60 cycles later. It updates its result register exactly when BUSY rises, and it drives that register onto the bus only while the read conditions hold. The stuck-BUSY case is entered only inside the watchdog scenario, and the model is released before the next start is expected.

// File: rtl/adcc_pkg.sv
package adcc_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETUP,
      ST_LOW,
      ST_WLO,
      ST_WHI
   } seq_st_e;

   // minimum time -> cycles, rounded up
   function automatic int unsigned cyc_ceil(input int unsigned ns, input int unsigned clk_ps);
      return (ns * 1000 + clk_ps - 1) / clk_ps;
   endfunction

   // maximum time -> cycles, rounded down
   function automatic int unsigned cyc_floor(input int unsigned ns, input int unsigned clk_ps);
      return (ns * 1000) / clk_ps;
   endfunction

endpackage

// File: rtl/adcc_sync.sv
module adcc_sync #(
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("adcc_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= {STAGES{RST_VAL}};
      else        sh <= {sh[STAGES-2:0], d_i};
   end

   assign q_o = sh[STAGES-1];

endmodule

// File: rtl/adcc_pace.sv
module adcc_pace #(
   parameter int unsigned PW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic          enable_i,
   input  logic [PW-1:0] period_i,
   output logic          due_o
);

   if (PW < 2) begin : g_bad_pw
      $error("adcc_pace: PW must be at least 2");
   end

   localparam logic [PW-1:0] SAT = {PW{1'b1}};

   logic [PW-1:0] since;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             since <= SAT;
      else if (start_i)       since <= PW'(1);
      else if (since != SAT)  since <= since + 1'b1;
   end

   assign due_o = enable_i && (since >= period_i);

endmodule

// File: rtl/adcc_seq.sv
module adcc_seq
   import adcc_pkg::*;
#(
   parameter int unsigned DW        = 16,
   parameter int unsigned LOW_CYC   = 8,
   parameter int unsigned SETUP_CYC = 2,
   parameter int unsigned TMO_CYC   = 2000
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go_i,
   input  logic          mode_sel_i,
   input  logic          ready_i,
   input  logic [DW-1:0] bus_i,
   output logic          cs_n_o,
   output logic          rc_o,
   output logic [DW-1:0] data_o,
   output logic          valid_o,
   output logic          err_o,
   output logic          start_o
);

   localparam int unsigned CNT_MAX = (LOW_CYC > SETUP_CYC) ? LOW_CYC : SETUP_CYC;
   localparam int unsigned CW      = $clog2(CNT_MAX + 1);
   localparam int unsigned TW      = $clog2(TMO_CYC + 1);

   if (LOW_CYC < 1 || SETUP_CYC < 1) begin : g_bad_win
      $error("adcc_seq: pulse windows must be at least one cycle");
   end
   if (TMO_CYC < 2) begin : g_bad_tmo
      $error("adcc_seq: TMO_CYC must be at least 2");
   end

   seq_st_e       st, st_n;
   logic [CW-1:0] cnt, cnt_n;
   logic [TW-1:0] tmo;
   logic          mode_q, mode_n;
   logic          have_prev;
   logic          cap, tmo_hit, start;
   logic          rc_n, csn_n;
   logic          waiting, wait_n;

   assign waiting = (st == ST_WLO) || (st == ST_WHI);
   assign wait_n  = (st_n == ST_WLO) || (st_n == ST_WHI);

   always_comb begin
      st_n    = st;
      cnt_n   = cnt;
      start   = 1'b0;
      cap     = 1'b0;
      tmo_hit = 1'b0;
      mode_n  = (st == ST_IDLE) ? mode_sel_i : mode_q;
      unique case (st)
         ST_IDLE: begin
            if (go_i && ready_i && (mode_sel_i == mode_q)) begin
               start = 1'b1;
               if (mode_sel_i) begin
                  st_n  = ST_SETUP;
                  cnt_n = CW'(SETUP_CYC - 1);
               end else begin
                  st_n  = ST_LOW;
                  cnt_n = CW'(LOW_CYC - 1);
               end
            end
         end
         ST_SETUP: begin
            if (cnt == '0) begin
               st_n  = ST_LOW;
               cnt_n = CW'(LOW_CYC - 1);
            end else begin
               cnt_n = cnt - 1'b1;
            end
         end
         ST_LOW: begin
            if (cnt == '0) begin
               st_n = ST_WLO;
               cap  = mode_q && have_prev;
            end else begin
               cnt_n = cnt - 1'b1;
            end
         end
         ST_WLO: if (!ready_i) st_n = ST_WHI;
         ST_WHI: begin
            if (ready_i) begin
               st_n = ST_IDLE;
               cap  = !mode_q;
            end
         end
         default: st_n = ST_IDLE;
      endcase
      if (waiting && (st_n != ST_IDLE) && (tmo == TW'(TMO_CYC - 1))) begin
         tmo_hit = 1'b1;
         st_n    = ST_IDLE;
      end
   end

   // pins are registered decodes of the next state: glitch-free
   assign rc_n  = !((st_n == ST_LOW) || (mode_n && (st_n == ST_SETUP)));
   assign csn_n = mode_n ? (st_n != ST_LOW) : 1'b0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         cnt       <= '0;
         tmo       <= '0;
         mode_q    <= 1'b1;
         have_prev <= 1'b0;
         rc_o      <= 1'b1;
         cs_n_o    <= 1'b1;
         data_o    <= '0;
         valid_o   <= 1'b0;
         err_o     <= 1'b0;
      end else begin
         st      <= st_n;
         cnt     <= cnt_n;
         mode_q  <= mode_n;
         rc_o    <= rc_n;
         cs_n_o  <= csn_n;
         valid_o <= cap;
         tmo     <= (waiting && wait_n) ? tmo + 1'b1 : '0;
         if (cap) data_o <= bus_i;
         if (tmo_hit)
            have_prev <= 1'b0;
         else if ((st == ST_IDLE) && (mode_sel_i != mode_q))
            have_prev <= 1'b0;
         else if ((st == ST_WHI) && (st_n == ST_IDLE))
            have_prev <= mode_q;
         if (start)        err_o <= 1'b0;
         else if (tmo_hit) err_o <= 1'b1;
      end
   end

   assign start_o = start;

   // R6
   valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o);

   // R2
   csn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((st != ST_IDLE) && !mode_q) |-> !cs_n_o);

   // R8
   err_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_o) |-> $past(waiting));

endmodule

// File: rtl/adc_conv_ctrl.sv
module adc_conv_ctrl
   import adcc_pkg::*;
#(
   parameter int unsigned DW          = 16,
   parameter int unsigned PW          = 16,
   parameter int unsigned CLK_PS      = 5000,
   parameter int unsigned START_NS    = 40,
   parameter int unsigned SETUP_NS    = 10,
   parameter int unsigned RC_MAX_NS   = 3000,
   parameter int unsigned TMO_NS      = 10000,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run_en,
   input  logic          mode_sel,
   input  logic [PW-1:0] period_cyc,
   input  logic          adc_busy_n,
   input  logic [DW-1:0] adc_data,
   output logic          adc_cs_n,
   output logic          adc_rc,
   output logic [DW-1:0] smp_data,
   output logic          smp_valid,
   output logic          tmo_err
);

   localparam int unsigned LOW_CYC    = cyc_ceil(START_NS, CLK_PS);
   localparam int unsigned SETUP_CYC  = cyc_ceil(SETUP_NS, CLK_PS);
   localparam int unsigned RC_MAX_CYC = cyc_floor(RC_MAX_NS, CLK_PS);
   localparam int unsigned TMO_CYC    = cyc_ceil(TMO_NS, CLK_PS);
   localparam int unsigned KW         = $clog2(RC_MAX_CYC + 2);

   if (SETUP_CYC + LOW_CYC > RC_MAX_CYC) begin : g_bad_rcmax
      $error("adc_conv_ctrl: convert pulse cannot fit the maximum low time");
   end
   if (DW < 1) begin : g_bad_dw
      $error("adc_conv_ctrl: DW must be positive");
   end

   logic busy_s;
   logic due;
   logic start;

   adcc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (adc_busy_n),
      .q_o   (busy_s)
   );

   adcc_pace #(.PW(PW)) u_pace (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start),
      .enable_i (run_en),
      .period_i (period_cyc),
      .due_o    (due)
   );

   adcc_seq #(
      .DW        (DW),
      .LOW_CYC   (LOW_CYC),
      .SETUP_CYC (SETUP_CYC),
      .TMO_CYC   (TMO_CYC)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .go_i       (due),
      .mode_sel_i (mode_sel),
      .ready_i    (busy_s),
      .bus_i      (adc_data),
      .cs_n_o     (adc_cs_n),
      .rc_o       (adc_rc),
      .data_o     (smp_data),
      .valid_o    (smp_valid),
      .err_o      (tmo_err),
      .start_o    (start)
   );

   // pin-level timing monitors
   logic          both_low;
   logic [KW-1:0] lowcnt, rclow;
   localparam logic [KW-1:0] KSAT = {KW{1'b1}};

   assign both_low = !adc_cs_n && !adc_rc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lowcnt <= '0;
         rclow  <= '0;
      end else begin
         lowcnt <= both_low ? ((lowcnt == KSAT) ? lowcnt : lowcnt + 1'b1) : '0;
         rclow  <= !adc_rc  ? ((rclow  == KSAT) ? rclow  : rclow  + 1'b1) : '0;
      end
   end

   // R2
   start_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!both_low && (lowcnt != '0)) |-> (lowcnt >= KW'(LOW_CYC)));

   // R2
   rc_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !adc_rc |-> (rclow < KW'(RC_MAX_CYC)));

   // R3
   cs_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(adc_cs_n) && !adc_rc) |-> !$past(adc_rc));

   // R4
   busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(both_low) |-> $past(busy_s));

endmodule

// File: tb/adc_conv_ctrl_tb.sv
`timescale 1ns/1ps
module adc_conv_ctrl_tb;

   localparam int DW   = 16;
   localparam int PW   = 16;
   localparam int CONV = 60;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          run_en = 1'b0;
   logic          mode_sel = 1'b1;
   logic [PW-1:0] period_cyc = 16'd200;
   logic          adc_busy_n = 1'b1;
   logic [DW-1:0] adc_data;
   logic          adc_cs_n, adc_rc, smp_valid, tmo_err;
   logic [DW-1:0] smp_data;

   always #2.5 clk = ~clk;

   adc_conv_ctrl u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .run_en     (run_en),
      .mode_sel   (mode_sel),
      .period_cyc (period_cyc),
      .adc_busy_n (adc_busy_n),
      .adc_data   (adc_data),
      .adc_cs_n   (adc_cs_n),
      .adc_rc     (adc_rc),
      .smp_data   (smp_data),
      .smp_valid  (smp_valid),
      .tmo_err    (tmo_err)
   );

   // converter model state
   logic [DW-1:0] res = '0;
   logic [DW-1:0] cur = '0;
   int            left = 0;
   int            seq_no = 0;
   bit            stuck = 1'b0;

   // bus: driven while chip select is low and either reading or pulsed mode
   assign adc_data = adc_cs_n ? '0 : ((adc_rc || mode_sel) ? res : '0);

   // monitor statistics
   int  cyc = 0;
   int  rc_run = 0, cs_run = 0;
   int  rc_w_min, rc_w_max, cs_w_min, cs_w_max, su_min, su_max;
   int  starts, last_start, int_min, int_max, viol;
   int  vcnt, vbad, vdouble, cs_high;
   bit  both_prev = 1'b0, cs_prev = 1'b1, v_prev = 1'b0;

   int  n_chk = 0, n_fail = 0;
   bit  done = 1'b0;

   task automatic clr_stats();
      rc_w_min = 1 << 30; rc_w_max = 0;
      cs_w_min = 1 << 30; cs_w_max = 0;
      su_min = 1 << 30;   su_max = 0;
      starts = 0; last_start = 0; int_min = 1 << 30; int_max = 0; viol = 0;
      vcnt = 0; vbad = 0; vdouble = 0; cs_high = 0;
   endtask

   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         // monitor
         if (cs_prev && !adc_cs_n && !adc_rc) begin
            if (rc_run < su_min) su_min = rc_run;
            if (rc_run > su_max) su_max = rc_run;
         end
         if (!adc_rc) rc_run++;
         else if (rc_run > 0) begin
            if (rc_run < rc_w_min) rc_w_min = rc_run;
            if (rc_run > rc_w_max) rc_w_max = rc_run;
            rc_run = 0;
         end
         if (!adc_cs_n) cs_run++;
         else begin
            cs_high++;
            if (cs_run > 0) begin
               if (cs_run < cs_w_min) cs_w_min = cs_run;
               if (cs_run > cs_w_max) cs_w_max = cs_run;
               cs_run = 0;
            end
         end
         if (smp_valid) begin
            vcnt++;
            if (smp_data != res) vbad++;
            if (v_prev) vdouble++;
         end
         v_prev = smp_valid;
         cs_prev = adc_cs_n;
         // converter model
         if (!adc_busy_n) begin
            if (!stuck) begin
               left--;
               if (left == 0) begin
                  res = cur;
                  adc_busy_n = 1'b1;
               end
            end
         end
         if (!adc_cs_n && !adc_rc && !both_prev) begin
            if (starts > 0) begin
               if (cyc - last_start < int_min) int_min = cyc - last_start;
               if (cyc - last_start > int_max) int_max = cyc - last_start;
            end
            starts++;
            last_start = cyc;
            if (!adc_busy_n) viol++;
            else begin
               seq_no++;
               cur = DW'(16'hA000 + seq_no * 16'h0135);
               left = CONV;
               adc_busy_n = 1'b0;
            end
         end
         both_prev = !adc_cs_n && !adc_rc;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset();
      wait_cyc(4);
      rst_n = 1'b1;
      wait_cyc(3);
      chk(adc_rc == 1'b1,    "R1", "adc_rc after reset",    int'(adc_rc), 1);
      chk(adc_cs_n == 1'b1,  "R1", "adc_cs_n after reset",  int'(adc_cs_n), 1);
      chk(smp_valid == 1'b0, "R1", "smp_valid after reset", int'(smp_valid), 0);
      chk(tmo_err == 1'b0,   "R1", "tmo_err after reset",   int'(tmo_err), 0);
   endtask

   task automatic t_idle();
      clr_stats();
      run_en = 1'b0;
      mode_sel = 1'b0;
      wait_cyc(150);
      mode_sel = 1'b1;
      wait_cyc(150);
      chk(starts == 0, "R9", "starts with run_en low", starts, 0);
   endtask

   task automatic t_mode_a();
      mode_sel = 1'b0;
      period_cyc = 16'd200;
      wait_cyc(20);
      clr_stats();
      run_en = 1'b1;
      wait_cyc(850);
      run_en = 1'b0;
      wait_cyc(300);
      chk(starts >= 4,     "R5", "held-select start count", starts, 4);
      chk(rc_w_min == 8,   "R2", "rc low width min", rc_w_min, 8);
      chk(rc_w_max == 8,   "R2", "rc low width max", rc_w_max, 8);
      chk(cs_high == 0,    "R2", "cs high cycles in held mode", cs_high, 0);
      chk(int_min == 200,  "R5", "start interval min", int_min, 200);
      chk(int_max == 200,  "R5", "start interval max", int_max, 200);
      chk(vcnt == starts,  "R6", "strobes per conversion", vcnt, starts);
      chk(vbad == 0,       "R6", "data mismatches", vbad, 0);
      chk(vdouble == 0,    "R6", "multi-cycle strobes", vdouble, 0);
      chk(viol == 0,       "R4", "starts while busy", viol, 0);
   endtask

   task automatic t_fast();
      mode_sel = 1'b0;
      period_cyc = 16'd5;
      wait_cyc(20);
      clr_stats();
      run_en = 1'b1;
      wait_cyc(600);
      run_en = 1'b0;
      wait_cyc(200);
      chk(int_min == CONV + 4, "R5", "busy-paced interval min", int_min, CONV + 4);
      chk(int_max == CONV + 4, "R5", "busy-paced interval max", int_max, CONV + 4);
      chk(viol == 0,           "R4", "starts while busy (fast)", viol, 0);
      chk(vcnt == starts,      "R6", "strobes per conversion (fast)", vcnt, starts);
   endtask

   task automatic t_mode_b();
      mode_sel = 1'b1;
      period_cyc = 16'd200;
      wait_cyc(20);
      clr_stats();
      run_en = 1'b1;
      wait_cyc(850);
      run_en = 1'b0;
      wait_cyc(300);
      chk(starts >= 4,         "R7", "pulsed-select start count", starts, 4);
      chk(su_min == 2,         "R3", "rc-to-cs setup min", su_min, 2);
      chk(su_max == 2,         "R3", "rc-to-cs setup max", su_max, 2);
      chk(cs_w_min == 8,       "R3", "cs low width min", cs_w_min, 8);
      chk(cs_w_max == 8,       "R3", "cs low width max", cs_w_max, 8);
      chk(rc_w_max == 10,      "R3", "rc low width (setup+pulse)", rc_w_max, 10);
      chk(vcnt == starts - 1,  "R7", "strobes lag by one", vcnt, starts - 1);
      chk(vbad == 0,           "R7", "previous-result mismatches", vbad, 0);
      chk(int_max == 200,      "R5", "pulsed-select interval", int_max, 200);
      chk(viol == 0,           "R4", "starts while busy (pulsed)", viol, 0);
   endtask

   task automatic t_timeout();
      mode_sel = 1'b0;
      period_cyc = 16'd200;
      wait_cyc(20);
      clr_stats();
      stuck = 1'b1;
      run_en = 1'b1;
      wait_cyc(2100);
      chk(tmo_err == 1'b1, "R8", "tmo_err after stuck busy", int'(tmo_err), 1);
      chk(vcnt == 0,       "R8", "strobes on timeout", vcnt, 0);
      chk(starts == 1,     "R4", "no restart while stuck", starts, 1);
      stuck = 1'b0;
      wait_cyc(40);
      chk(tmo_err == 1'b1, "R8", "tmo_err held until next start", int'(tmo_err), 1);
      wait_cyc(250);
      chk(tmo_err == 1'b0, "R8", "tmo_err cleared by next start", int'(tmo_err), 0);
      run_en = 1'b0;
      wait_cyc(200);
   endtask

   initial begin
      clr_stats();
      t_reset();
      t_idle();
      t_mode_a();
      t_fast();
      t_mode_b();
      t_timeout();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule